// File: doc/BRIEF.md
# Auto-Retransmit and Interrupt Controller

This block sequences the transmit side of an acknowledged radio link. When a transmission is requested it asks the radio to send. Once the radio reports the send complete, it either finishes at once (packet marked as needing no acknowledgement, or acknowledgement disabled) or opens a listening window. The window is a multiple of 250 us chosen by a 4-bit delay field. If no acknowledgement arrives before the window closes, the packet is sent again, up to a programmed retry count. Running out of retries raises a sticky max-retry flag, and further starts are refused until software clears that flag.

Two loss counters give a view of channel quality. The per-packet retry counter restarts with every new packet. The lost-window counter runs across packets, stops at 15, and is cleared only by a write to the channel register. Three sticky status flags (receive-data-ready, data-sent, max-retry) are cleared by write-1 strobes. They drive an active-low interrupt through per-flag mask bits.

Top module: `retx_irq_ctrl`

## Requirements
- R1: After reset all three flags are 0, both counters are 0, radio_tx_req and radio_rx_req are 0, and irq_n is 1.
- R2: A tx_start sampled while idle with max_rt clear raises radio_tx_req from the next cycle and clears arc_cnt to 0.
- R3: If the packet is marked no-ack (pkt_no_ack=1) or aa_en=0, a tx_done pulse sets tx_ds and returns to idle on the next cycle, with no listening window (radio_rx_req stays 0).
- R4: For an acknowledged packet, radio_rx_req is high for exactly (ARD+1)×STEP consecutive cycles after tx_done, where STEP = CLK_HZ×250/1,000,000 and ARD is the unsigned 4-bit delay field.
- R5: An ack_rx pulse during the listening window sets tx_ds and returns to idle on the next cycle. An ack_rx in the last cycle of the window wins over the timeout.
- R6: When a window expires and arc_cnt is below ARC, the packet is retransmitted (radio_tx_req high the next cycle) and arc_cnt increments by 1. ARC=0 permits no retransmission.
- R7: When a window expires with arc_cnt equal to ARC, max_rt is set and the controller returns to idle with both radio requests low, leaving arc_cnt at ARC.
- R8: While max_rt is set, tx_start is ignored and radio_tx_req stays 0.
- R9: plos_cnt increments by 1 for every expired window, saturates at 15, and clears to 0 on ch_wr, which takes priority over an increment.
- R10: Each flag is cleared by a 1 on its clear strobe. A set and a clear of the same flag in the same cycle leave the flag at 1.
- R11: irq_n is 0 exactly when some flag is 1 and its mask bit is 0. Flag bits are ordered {max_rt, tx_ds, rx_dr} and masks likewise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_start | input | 1 | Request to begin sending a new packet |
| pkt_no_ack | input | 1 | Packet needs no acknowledgement (sampled at start) |
| aa_en | input | 1 | Auto-acknowledge enable (sampled at start) |
| ard | input | 4 | Listening window length, (ard+1)×250 us |
| arc | input | 4 | Maximum retransmissions, 0 disables |
| tx_done | input | 1 | Radio finished sending (pulse) |
| ack_rx | input | 1 | Acknowledgement received (pulse) |
| rx_dr_set | input | 1 | Receive path stored a payload (pulse) |
| ch_wr | input | 1 | Channel register write strobe |
| clr_rx_dr | input | 1 | Write-1 clear of rx_dr |
| clr_tx_ds | input | 1 | Write-1 clear of tx_ds |
| clr_max_rt | input | 1 | Write-1 clear of max_rt |
| mask_rx_dr | input | 1 | 1 keeps rx_dr off irq_n |
| mask_tx_ds | input | 1 | 1 keeps tx_ds off irq_n |
| mask_max_rt | input | 1 | 1 keeps max_rt off irq_n |
| radio_tx_req | output | 1 | Radio send request |
| radio_rx_req | output | 1 | Radio listen request (acknowledgement window) |
| rx_dr | output | 1 | Receive-data-ready flag |
| tx_ds | output | 1 | Data-sent flag |
| max_rt | output | 1 | Retries-exhausted flag |
| arc_cnt | output | 4 | Retransmissions of the current packet |
| plos_cnt | output | 4 | Saturating count of expired windows |
| irq_n | output | 1 | Active-low interrupt |

## Verification
A timer that is loaded wrongly or counts off by one shows up at once as a wrong listening-window length on radio_rx_req, and this is measured for every delay code. A sequencer in the wrong state shows within one cycle of the next tx_done or window expiry. It appears as a missing retransmission, a premature max_rt, or an acknowledgement that is lost when it coincides with the timeout. Counter faults appear as arc_cnt or plos_cnt values that drift from the arithmetic model over long retry sweeps, especially at the saturation point. Flag and mask faults appear on irq_n across all mask and flag combinations.

// File: rtl/retx_pkg.sv
package retx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_TX   = 2'd1,
    ST_WAIT = 2'd2
  } retx_state_e;

  localparam int NFLAGS      = 3;
  localparam int FLAG_RX_DR  = 0;
  localparam int FLAG_TX_DS  = 1;
  localparam int FLAG_MAX_RT = 2;

endpackage

// File: rtl/retx_ack_timer.sv
module retx_ack_timer #(
  parameter int CLK_HZ  = 50_000_000,
  parameter int STEP_US = 250,
  parameter int ARD_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             run,
  input  logic [ARD_W-1:0] ard,
  output logic             expired
);

  localparam int STEP_CYC = int'((64'(CLK_HZ) * 64'(STEP_US)) / 64'd1_000_000);
  localparam int MAX_CYC  = (2 ** ARD_W) * STEP_CYC;
  localparam int TMR_W    = $clog2(MAX_CYC + 1);

  logic [TMR_W-1:0] cnt_q, cnt_d, load_val;
  logic             cnt_en, cnt_nz;

  always_comb begin
    load_val = TMR_W'((int'(ard) + 1) * STEP_CYC - 1);
  end

  assign cnt_nz  = |cnt_q;
  assign expired = run & ~cnt_nz;
  assign cnt_en  = load | (run & cnt_nz);

  always_comb begin
    if (load) cnt_d = load_val;
    else      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R4
  load_clears_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !expired);

endmodule

// File: rtl/retx_loss_cnt.sv
module retx_loss_cnt #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pkt_start,
  input  logic             retry,
  input  logic             loss,
  input  logic             ch_wr,
  output logic [CNT_W-1:0] arc_cnt,
  output logic [CNT_W-1:0] plos_cnt
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] arc_q, arc_d, plos_q, plos_d;
  logic             arc_en, plos_en;

  assign arc_en = pkt_start | retry;
  always_comb begin
    if (pkt_start) arc_d = '0;
    else           arc_d = arc_q + 1'b1;
  end

  assign plos_en = ch_wr | (loss & (plos_q != CNT_MAX));
  always_comb begin
    if (ch_wr) plos_d = '0;
    else       plos_d = plos_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arc_q  <= '0;
      plos_q <= '0;
    end else begin
      if (arc_en)  arc_q  <= arc_d;
      if (plos_en) plos_q <= plos_d;
    end
  end

  assign arc_cnt  = arc_q;
  assign plos_cnt = plos_q;

  // R9
  plos_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ch_wr |=> plos_cnt == '0);
  // R9
  plos_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ch_wr |=> plos_cnt >= $past(plos_cnt));
  // R2
  arc_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_start |=> arc_cnt == '0);

endmodule

// File: rtl/retx_seq_fsm.sv
module retx_seq_fsm
  import retx_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_start,
  input  logic             pkt_no_ack,
  input  logic             aa_en,
  input  logic             tx_done,
  input  logic             ack_rx,
  input  logic             expired,
  input  logic             max_rt,
  input  logic [CNT_W-1:0] arc,
  input  logic [CNT_W-1:0] arc_cnt,
  output logic             tx_req,
  output logic             rx_req,
  output logic             tmr_load,
  output logic             tmr_run,
  output logic             pkt_start,
  output logic             retry,
  output logic             loss,
  output logic             set_tx_ds,
  output logic             set_max_rt
);

  retx_state_e state_q, state_d;
  logic        noack_q, noack_d;

  always_comb begin
    state_d    = state_q;
    noack_d    = noack_q;
    tmr_load   = 1'b0;
    tmr_run    = 1'b0;
    pkt_start  = 1'b0;
    retry      = 1'b0;
    loss       = 1'b0;
    set_tx_ds  = 1'b0;
    set_max_rt = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (tx_start && !max_rt) begin
          state_d   = ST_TX;
          pkt_start = 1'b1;
          noack_d   = pkt_no_ack | ~aa_en;
        end
      end
      ST_TX: begin
        if (tx_done) begin
          if (noack_q) begin
            state_d   = ST_IDLE;
            set_tx_ds = 1'b1;
          end else begin
            state_d  = ST_WAIT;
            tmr_load = 1'b1;
          end
        end
      end
      ST_WAIT: begin
        tmr_run = 1'b1;
        if (ack_rx) begin
          state_d   = ST_IDLE;
          set_tx_ds = 1'b1;
        end else if (expired) begin
          loss = 1'b1;
          if (arc_cnt < arc) begin
            state_d = ST_TX;
            retry   = 1'b1;
          end else begin
            state_d    = ST_IDLE;
            set_max_rt = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      noack_q <= 1'b0;
    end else begin
      state_q <= state_d;
      noack_q <= noack_d;
    end
  end

  assign tx_req = (state_q == ST_TX);
  assign rx_req = (state_q == ST_WAIT);

  // R8
  lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && max_rt) |=> state_q == ST_IDLE);
  // R5
  ack_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rx && rx_req) |=> (!rx_req && !tx_req));
  // R3
  noack_no_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_req && tx_done && noack_q) |=> !rx_req);

endmodule

// File: rtl/retx_status_flags.sv
module retx_status_flags
  import retx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NFLAGS-1:0] set,
  input  logic [NFLAGS-1:0] clr,
  input  logic [NFLAGS-1:0] mask,
  output logic [NFLAGS-1:0] flag,
  output logic              irq_n
);

  for (genvar i = 0; i < NFLAGS; i++) begin : g_flag
    logic q, d, en;
    assign en = set[i] | clr[i];
    assign d  = set[i] | (q & ~clr[i]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= 1'b0;
      else if (en) q <= d;
    end
    assign flag[i] = q;

    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> flag[i]);
    // R10
    w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[i] && !set[i]) |=> !flag[i]);
  end

  assign irq_n = ~|(flag & ~mask);

endmodule

// File: rtl/retx_irq_ctrl.sv
module retx_irq_ctrl
  import retx_pkg::*;
#(
  parameter int CLK_HZ  = 50_000_000,
  parameter int STEP_US = 250,
  parameter int CNT_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_start,
  input  logic             pkt_no_ack,
  input  logic             aa_en,
  input  logic [CNT_W-1:0] ard,
  input  logic [CNT_W-1:0] arc,
  input  logic             tx_done,
  input  logic             ack_rx,
  input  logic             rx_dr_set,
  input  logic             ch_wr,
  input  logic             clr_rx_dr,
  input  logic             clr_tx_ds,
  input  logic             clr_max_rt,
  input  logic             mask_rx_dr,
  input  logic             mask_tx_ds,
  input  logic             mask_max_rt,
  output logic             radio_tx_req,
  output logic             radio_rx_req,
  output logic             rx_dr,
  output logic             tx_ds,
  output logic             max_rt,
  output logic [CNT_W-1:0] arc_cnt,
  output logic [CNT_W-1:0] plos_cnt,
  output logic             irq_n
);

  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  logic tmr_load, tmr_run, expired;
  logic pkt_start, retry, loss, set_tx_ds, set_max_rt;
  logic [NFLAGS-1:0] flag_set, flag_clr, flag_mask, flags;

  retx_ack_timer #(
    .CLK_HZ (CLK_HZ),
    .STEP_US(STEP_US),
    .ARD_W  (CNT_W)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .load   (tmr_load),
    .run    (tmr_run),
    .ard    (ard),
    .expired(expired)
  );

  retx_seq_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .tx_start  (tx_start),
    .pkt_no_ack(pkt_no_ack),
    .aa_en     (aa_en),
    .tx_done   (tx_done),
    .ack_rx    (ack_rx),
    .expired   (expired),
    .max_rt    (max_rt),
    .arc       (arc),
    .arc_cnt   (arc_cnt),
    .tx_req    (radio_tx_req),
    .rx_req    (radio_rx_req),
    .tmr_load  (tmr_load),
    .tmr_run   (tmr_run),
    .pkt_start (pkt_start),
    .retry     (retry),
    .loss      (loss),
    .set_tx_ds (set_tx_ds),
    .set_max_rt(set_max_rt)
  );

  retx_loss_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .pkt_start(pkt_start),
    .retry    (retry),
    .loss     (loss),
    .ch_wr    (ch_wr),
    .arc_cnt  (arc_cnt),
    .plos_cnt (plos_cnt)
  );

  always_comb begin
    flag_set              = '0;
    flag_clr              = '0;
    flag_mask             = '0;
    flag_set[FLAG_RX_DR]  = rx_dr_set;
    flag_set[FLAG_TX_DS]  = set_tx_ds;
    flag_set[FLAG_MAX_RT] = set_max_rt;
    flag_clr[FLAG_RX_DR]  = clr_rx_dr;
    flag_clr[FLAG_TX_DS]  = clr_tx_ds;
    flag_clr[FLAG_MAX_RT] = clr_max_rt;
    flag_mask[FLAG_RX_DR]  = mask_rx_dr;
    flag_mask[FLAG_TX_DS]  = mask_tx_ds;
    flag_mask[FLAG_MAX_RT] = mask_max_rt;
  end

  retx_status_flags u_flags (
    .clk  (clk),
    .rst_n(rst_core_n),
    .set  (flag_set),
    .clr  (flag_clr),
    .mask (flag_mask),
    .flag (flags),
    .irq_n(irq_n)
  );

  assign rx_dr  = flags[FLAG_RX_DR];
  assign tx_ds  = flags[FLAG_TX_DS];
  assign max_rt = flags[FLAG_MAX_RT];

  // R7
  retry_bound_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (radio_rx_req || radio_tx_req) |-> arc_cnt <= arc || $changed(arc));

endmodule

// File: tb/tb_retx_irq_ctrl.sv
module tb_retx_irq_ctrl;

  localparam int CLK_HZ = 40_000;
  localparam int STEP   = CLK_HZ * 250 / 1_000_000;

  logic clk = 1'b0;
  logic rst_n;
  logic tx_start, pkt_no_ack, aa_en, tx_done, ack_rx, rx_dr_set, ch_wr;
  logic clr_rx_dr, clr_tx_ds, clr_max_rt, mask_rx_dr, mask_tx_ds, mask_max_rt;
  logic [3:0] ard, arc, arc_cnt, plos_cnt;
  logic radio_tx_req, radio_rx_req, rx_dr, tx_ds, max_rt, irq_n;

  int n_chk = 0;
  int n_bad = 0;
  int plos_exp = 0;

  always #10 clk = ~clk;

  retx_irq_ctrl #(.CLK_HZ(CLK_HZ)) dut (
    .clk(clk), .rst_n(rst_n), .tx_start(tx_start), .pkt_no_ack(pkt_no_ack),
    .aa_en(aa_en), .ard(ard), .arc(arc), .tx_done(tx_done), .ack_rx(ack_rx),
    .rx_dr_set(rx_dr_set), .ch_wr(ch_wr), .clr_rx_dr(clr_rx_dr),
    .clr_tx_ds(clr_tx_ds), .clr_max_rt(clr_max_rt), .mask_rx_dr(mask_rx_dr),
    .mask_tx_ds(mask_tx_ds), .mask_max_rt(mask_max_rt),
    .radio_tx_req(radio_tx_req), .radio_rx_req(radio_rx_req), .rx_dr(rx_dr),
    .tx_ds(tx_ds), .max_rt(max_rt), .arc_cnt(arc_cnt), .plos_cnt(plos_cnt),
    .irq_n(irq_n)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string r, input int act, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp_v);
    end
  endtask

  task automatic add_loss();
    if (plos_exp < 15) plos_exp++;
  endtask

  task automatic xact(input int ard_i, input int arc_i, input bit noack_pkt,
                      input bit aa, input int ack_on, input int ack_at);
    int  n_exp = (ard_i + 1) * STEP;
    bit  eff   = noack_pkt || !aa;
    int  att   = 0;
    bit  done  = 0;
    int  w;
    bit  ackd;
    ard = 4'(ard_i); arc = 4'(arc_i); pkt_no_ack = noack_pkt; aa_en = aa;
    tx_start = 1'b1; step(); tx_start = 1'b0;
    chk(radio_tx_req == 1'b1, "R2 tx_req after start", int'(radio_tx_req), 1);
    chk(arc_cnt == 4'd0, "R2 arc_cnt cleared", int'(arc_cnt), 0);
    while (!done) begin
      step(); step();
      tx_done = 1'b1; step(); tx_done = 1'b0;
      if (eff) begin
        chk(tx_ds == 1'b1, "R3 tx_ds after no-ack send", int'(tx_ds), 1);
        chk(!radio_rx_req && !radio_tx_req, "R3 no window", int'(radio_rx_req), 0);
        done = 1;
      end else begin
        w = 0; ackd = 0;
        while (radio_rx_req && w <= n_exp) begin
          if (att == ack_on && w == ack_at) begin
            ack_rx = 1'b1; step(); ack_rx = 1'b0; ackd = 1;
            break;
          end
          w++; step();
        end
        if (ackd) begin
          chk(!radio_rx_req && !radio_tx_req, "R5 idle after ack", int'(radio_rx_req), 0);
          chk(tx_ds == 1'b1, "R5 tx_ds on ack", int'(tx_ds), 1);
          chk(arc_cnt == 4'(att), "R6 arc_cnt at ack", int'(arc_cnt), att);
          done = 1;
        end else begin
          chk(w == n_exp, "R4 window length", w, n_exp);
          add_loss();
          if (att < arc_i) begin
            att++;
            chk(radio_tx_req == 1'b1, "R6 retransmit", int'(radio_tx_req), 1);
            chk(arc_cnt == 4'(att), "R6 arc_cnt step", int'(arc_cnt), att);
          end else begin
            chk(max_rt == 1'b1, "R7 max_rt set", int'(max_rt), 1);
            chk(!radio_tx_req && !radio_rx_req, "R7 idle", int'(radio_tx_req), 0);
            chk(arc_cnt == 4'(arc_i), "R7 arc_cnt final", int'(arc_cnt), arc_i);
            done = 1;
          end
        end
      end
    end
    chk(plos_cnt == 4'(plos_exp), "R9 plos_cnt", int'(plos_cnt), plos_exp);
  endtask

  task automatic clr_all();
    clr_rx_dr = 1'b1; clr_tx_ds = 1'b1; clr_max_rt = 1'b1; step();
    clr_rx_dr = 1'b0; clr_tx_ds = 1'b0; clr_max_rt = 1'b0;
    chk({max_rt, tx_ds, rx_dr} == 3'b000, "R10 cleared", int'({max_rt, tx_ds, rx_dr}), 0);
  endtask

  task automatic pulse_ch_wr();
    ch_wr = 1'b1; step(); ch_wr = 1'b0;
    plos_exp = 0;
    chk(plos_cnt == 4'd0, "R9 ch_wr clears", int'(plos_cnt), 0);
  endtask

  initial begin
    repeat (190_000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    tx_start = 0; pkt_no_ack = 0; aa_en = 1; tx_done = 0; ack_rx = 0;
    rx_dr_set = 0; ch_wr = 0; clr_rx_dr = 0; clr_tx_ds = 0; clr_max_rt = 0;
    mask_rx_dr = 0; mask_tx_ds = 0; mask_max_rt = 0; ard = 0; arc = 0;
    repeat (5) step();
    // R1 reset state
    chk({max_rt, tx_ds, rx_dr} == 3'b000, "R1 flags", int'({max_rt, tx_ds, rx_dr}), 0);
    chk(arc_cnt == 0 && plos_cnt == 0, "R1 counters", int'(plos_cnt), 0);
    chk(!radio_tx_req && !radio_rx_req, "R1 radio idle", int'(radio_tx_req), 0);
    chk(irq_n == 1'b1, "R1 irq_n", int'(irq_n), 1);
    rst_n = 1'b1;
    repeat (4) step();
    chk(irq_n == 1'b1 && !radio_tx_req, "R1 after release", int'(irq_n), 1);

    // R3 no-ack packets and auto-ack disabled
    for (int a = 0; a < 4; a++) begin
      xact(a, 3, 1'b1, 1'b1, -1, 0);
      chk(irq_n == 1'b0, "R11 tx_ds irq", int'(irq_n), 0);
      clr_all();
    end
    xact(2, 3, 1'b0, 1'b0, -1, 0);
    clr_all();

    // R4 R7 every delay code with no retries; R9 saturation follows
    for (int a = 0; a < 16; a++) begin
      xact(a, 0, 1'b0, 1'b1, -1, 0);
      if (a == 5) begin
        // R8 start refused while max_rt set
        tx_start = 1'b1; step(); tx_start = 1'b0;
        for (int k = 0; k < 6; k++) begin
          chk(!radio_tx_req && !radio_rx_req, "R8 lockout", int'(radio_tx_req), 0);
          step();
        end
      end
      clr_all();
    end
    chk(plos_cnt == 4'd15, "R9 saturated", int'(plos_cnt), 15);
    pulse_ch_wr();

    // R6 R7 every retry count with the shortest window
    for (int c = 0; c < 16; c++) begin
      xact(0, c, 1'b0, 1'b1, -1, 0);
      clr_all();
    end
    pulse_ch_wr();

    // R5 acknowledgements at window start, middle and last cycle
    for (int on = 0; on < 4; on++) begin
      for (int p = 0; p < 3; p++) begin
        int at = (p == 0) ? 0 : (p == 1) ? 7 : 2 * STEP - 1;
        xact(1, 3, 1'b0, 1'b1, on, at);
        chk(max_rt == 1'b0, "R5 no max_rt on ack", int'(max_rt), 0);
        clr_all();
      end
    end

    // R10 set and clear together
    rx_dr_set = 1'b1; clr_rx_dr = 1'b1; step(); rx_dr_set = 0; clr_rx_dr = 0;
    chk(rx_dr == 1'b1, "R10 set wins from 0", int'(rx_dr), 1);
    rx_dr_set = 1'b1; clr_rx_dr = 1'b1; step(); rx_dr_set = 0; clr_rx_dr = 0;
    chk(rx_dr == 1'b1, "R10 set wins from 1", int'(rx_dr), 1);
    clr_all();

    // R11 every flag subset against every mask
    for (int f = 0; f < 8; f++) begin
      rx_dr_set = 1'b1; step(); rx_dr_set = 1'b0;
      xact(0, 3, 1'b1, 1'b1, -1, 0);
      xact(0, 0, 1'b0, 1'b1, -1, 0);
      chk({max_rt, tx_ds, rx_dr} == 3'b111, "R10 all set", int'({max_rt, tx_ds, rx_dr}), 7);
      clr_max_rt = !f[2]; clr_tx_ds = !f[1]; clr_rx_dr = !f[0]; step();
      clr_max_rt = 0; clr_tx_ds = 0; clr_rx_dr = 0;
      chk({max_rt, tx_ds, rx_dr} == 3'(f), "R10 partial clear", int'({max_rt, tx_ds, rx_dr}), f);
      for (int m = 0; m < 8; m++) begin
        mask_max_rt = m[2]; mask_tx_ds = m[1]; mask_rx_dr = m[0]; step();
        chk(irq_n == !(|(3'(f) & ~3'(m))), "R11 irq_n", int'(irq_n), int'(!(|(3'(f) & ~3'(m)))));
      end
      mask_max_rt = 0; mask_tx_ds = 0; mask_rx_dr = 0;
      clr_all();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule